// File: doc/BRIEF.md
# Per-channel Zero-data Detector

This block watches a stereo pair of sample streams, one sample per strobe, and raises a flag for each channel once that channel has carried only zero samples for a configured run length (8192 samples by default). A nonzero sample clears the run at once. An optional combined mode makes both flags wait until both channels have completed a zero run. A polarity input selects whether a flag signals detection with a 1 or a 0.

A soft-reset input forces both outputs high. After soft reset drops, the outputs stay high for a short number of further strobes before normal detection resumes. A "clock stopped" input stands in for loss of the sample clocks: while it is set, detection is off and the runs restart.

All configuration inputs are static levels driven by the surrounding control logic. The enable input is expected to default to 0 and the combined-mode input to 0 (separate channels).

Top module: `zero_run_detect`

## Requirements
- R1: A channel is zero-active once exactly RUN_LEN consecutive strobes have carried a zero sample on it. It is not active after RUN_LEN-1 such strobes. The flag changes in the cycle after the clock edge that takes the last strobe.
- R2: A strobe that carries a nonzero sample, in any bit, makes that channel inactive from the next cycle and restarts its run from zero.
- R3: Sample values present without a strobe have no effect on the runs or the flags.
- R4: With combined_i=1, both flags are active only while both channels are zero-active, and the two flags are always equal outside soft-reset forcing.
- R5: With det_en_i=0, both flags sit at the inactive level and both runs are cleared.
- R6: The active level is 1 when invert_i=0 and 0 when invert_i=1. The inactive level is the opposite value.
- R7: While soft_rst_i=1, both flags are 1 regardless of polarity, enable or data, and both runs are cleared.
- R8: After soft_rst_i falls, both flags stay 1 until REL_DLY further strobes have occurred, then follow R1 to R6. Runs count from zero from the first strobe after release.
- R9: While clk_stop_i=1, both flags are at the inactive level and both runs are cleared.
- R10: Each run saturates at RUN_LEN, so a flag stays active for a zero run of any length beyond RUN_LEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strobe_i | input | 1 | One-cycle pulse marking a valid sample pair |
| left_i | input | SAMPLE_W | Left channel sample |
| right_i | input | SAMPLE_W | Right channel sample |
| det_en_i | input | 1 | Detection enable |
| combined_i | input | 1 | 1: both channels must be zero for either flag |
| invert_i | input | 1 | 1: flags active low |
| soft_rst_i | input | 1 | Soft reset, forces both flags high |
| clk_stop_i | input | 1 | Sample clocks stopped, detection off |
| flag_l_o | output | 1 | Left channel zero flag |
| flag_r_o | output | 1 | Right channel zero flag |

## Verification
The bench uses a short run length. It checks both sides of the threshold: one strobe before the run completes and the strobe that completes it, so an off-by-one counter flags too early or too late. It then sweeps a single set bit across every bit position of the sample word. A detector that compares only part of the word would keep the flag up on one of those positions.

Nonzero data is held on the inputs without a strobe, which catches a design that samples the data on every cycle. Combined mode is checked with only one channel complete. Polarity is checked in both the active and the inactive state, which exposes an inversion that was applied to the wrong term.

Around soft reset, the bench checks the forced-high level under both polarities. It counts the release strobes one at a time, so a release that comes early, comes late or never comes all show up. It also checks that runs restart after soft reset and after a clock stop rather than resuming where they left off.

// File: rtl/zrd_pkg.sv
package zrd_pkg;
  typedef struct packed {
    logic en;
    logic combined;
    logic invert;
  } zrd_cfg_t;
endpackage

// File: rtl/zrd_run_ctr.sv
module zrd_run_ctr #(
  parameter int SAMPLE_W = 24,
  parameter int RUN_LEN  = 8192
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                strobe_i,
  input  logic                clr_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                zero_o
);
  localparam int CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_LEN);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i)              cnt_q <= '0;
    else if (strobe_i) begin
      if (sample_i != '0)        cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign zero_o = (cnt_q == CNT_MAX);

  AST_RUN_SATURATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX); // R10
  AST_NONZERO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && sample_i != '0) |=> (cnt_q == '0)); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_i && !clr_i) |=> $stable(cnt_q)); // R3
endmodule

// File: rtl/zrd_rel_hold.sv
module zrd_rel_hold #(
  parameter int REL_DLY = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic soft_rst_i,
  output logic force_o
);
  localparam int HW = $clog2(REL_DLY + 1);
  localparam logic [HW-1:0] HOLD_INIT = HW'(REL_DLY);

  logic [HW-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        hold_q <= '0;
    else if (soft_rst_i)                hold_q <= HOLD_INIT;
    else if (strobe_i && hold_q != '0)  hold_q <= hold_q - 1'b1;
  end

  assign force_o = soft_rst_i || (hold_q != '0);

  AST_HOLD_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (hold_q == HOLD_INIT)); // R8
  AST_HOLD_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q <= HOLD_INIT); // R8
endmodule

// File: rtl/zrd_flag_map.sv
module zrd_flag_map
  import zrd_pkg::*;
(
  input  zrd_cfg_t cfg_i,
  input  logic     clk_stop_i,
  input  logic     force_i,
  input  logic     zero_l_i,
  input  logic     zero_r_i,
  output logic     flag_l_o,
  output logic     flag_r_o
);
  logic live, act_l, act_r;

  always_comb begin
    live  = cfg_i.en && !clk_stop_i;
    act_l = live && (cfg_i.combined ? (zero_l_i && zero_r_i) : zero_l_i);
    act_r = live && (cfg_i.combined ? (zero_l_i && zero_r_i) : zero_r_i);
    flag_l_o = force_i ? 1'b1 : (act_l ^ cfg_i.invert);
    flag_r_o = force_i ? 1'b1 : (act_r ^ cfg_i.invert);
  end
endmodule

// File: rtl/zero_run_detect.sv
module zero_run_detect
  import zrd_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int RUN_LEN  = 8192,
  parameter int REL_DLY  = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                strobe_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  input  logic                det_en_i,
  input  logic                combined_i,
  input  logic                invert_i,
  input  logic                soft_rst_i,
  input  logic                clk_stop_i,
  output logic                flag_l_o,
  output logic                flag_r_o
);
  localparam int NCH = 2;

  zrd_cfg_t cfg;
  logic [NCH-1:0][SAMPLE_W-1:0] samp;
  logic [NCH-1:0] zero;
  logic clr, forced;

  assign cfg  = '{en: det_en_i, combined: combined_i, invert: invert_i};
  assign samp = {right_i, left_i};
  assign clr  = soft_rst_i || clk_stop_i || !det_en_i;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    zrd_run_ctr #(.SAMPLE_W(SAMPLE_W), .RUN_LEN(RUN_LEN)) u_run (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .strobe_i(strobe_i),
      .clr_i   (clr),
      .sample_i(samp[c]),
      .zero_o  (zero[c])
    );
  end

  zrd_rel_hold #(.REL_DLY(REL_DLY)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strobe_i  (strobe_i),
    .soft_rst_i(soft_rst_i),
    .force_o   (forced)
  );

  zrd_flag_map u_map (
    .cfg_i     (cfg),
    .clk_stop_i(clk_stop_i),
    .force_i   (forced),
    .zero_l_i  (zero[0]),
    .zero_r_i  (zero[1]),
    .flag_l_o  (flag_l_o),
    .flag_r_o  (flag_r_o)
  );

  AST_SOFT_RST_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |-> (flag_l_o && flag_r_o)); // R7
  AST_COMBINED_EQUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (combined_i && !forced) |-> (flag_l_o == flag_r_o)); // R4
  AST_DISABLED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!det_en_i && !forced) |-> (flag_l_o == invert_i && flag_r_o == invert_i)); // R5
  AST_STOPPED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_stop_i && !forced) |-> (flag_l_o == invert_i && flag_r_o == invert_i)); // R9
endmodule

// File: tb/zero_run_detect_tb.sv
`timescale 1ns/1ps
module zero_run_detect_tb;
  localparam int SW = 8;
  localparam int RL = 16;
  localparam int RD = 2;

  logic clk = 0, rst_ni = 0, strobe = 0;
  logic [SW-1:0] left = '0, right = '0;
  logic en = 0, comb = 0, inv = 0, srst = 0, stop = 0;
  logic fl, fr;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  zero_run_detect #(.SAMPLE_W(SW), .RUN_LEN(RL), .REL_DLY(RD)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .strobe_i(strobe), .left_i(left), .right_i(right),
    .det_en_i(en), .combined_i(comb), .invert_i(inv), .soft_rst_i(srst),
    .clk_stop_i(stop), .flag_l_o(fl), .flag_r_o(fr));

  task automatic chk(input string req, input logic [1:0] exp);
    n_chk++;
    if ({fl, fr} !== exp) begin
      n_bad++;
      $display("FAIL %s: got l,r=%b expected %b", req, {fl, fr}, exp);
    end
  endtask

  task automatic stb(input logic [SW-1:0] l, input logic [SW-1:0] r);
    @(negedge clk); left = l; right = r; strobe = 1;
    @(negedge clk); strobe = 0;
  endtask

  task automatic zeros(input int n);
    for (int i = 0; i < n; i++) stb('0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R5 reset", 2'b00);
    rst_ni = 1;
    @(negedge clk); en = 1;
    zeros(RL - 1);       chk("R1 one short", 2'b00);
    zeros(1);            chk("R1 complete", 2'b11);
    zeros(3 * RL);       chk("R10 saturate", 2'b11);
    for (int b = 0; b < SW; b++) begin
      stb(SW'(1) << b, '0); chk("R2 bit sweep", 2'b01);
      zeros(RL - 1);        chk("R2 restart short", 2'b01);
      zeros(1);             chk("R2 restart full", 2'b11);
    end
    @(negedge clk); left = 8'hff; right = 8'h5a;
    repeat (6) @(negedge clk);
    chk("R3 no strobe", 2'b11);
    comb = 1;
    stb(8'h01, '0);      chk("R4 one channel", 2'b00);
    zeros(RL - 1);       chk("R4 short", 2'b00);
    zeros(1);            chk("R4 both", 2'b11);
    inv = 1;             @(negedge clk); chk("R6 active low", 2'b00);
    stb('0, 8'h80);      chk("R6 inactive high", 2'b11);
    comb = 0;            @(negedge clk); chk("R6 separate", 2'b01);
    en = 0;              @(negedge clk); chk("R5 disabled inv", 2'b11);
    inv = 0;             @(negedge clk); chk("R5 disabled", 2'b00);
    en = 1; zeros(RL - 1); chk("R5 run cleared", 2'b00);
    zeros(1);            chk("R5 rerun", 2'b11);
    inv = 1; srst = 1;   zeros(3); chk("R7 forced inv", 2'b11);
    inv = 0;             @(negedge clk); chk("R7 forced", 2'b11);
    en = 0;              @(negedge clk); chk("R7 forced disabled", 2'b11);
    en = 1; srst = 0;    @(negedge clk); chk("R8 hold no strobe", 2'b11);
    for (int i = 1; i < RD; i++) begin zeros(1); chk("R8 hold", 2'b11); end
    zeros(1);            chk("R8 released", 2'b00);
    zeros(RL - RD - 1);  chk("R8 restart short", 2'b00);
    zeros(1);            chk("R8 restart full", 2'b11);
    stop = 1;            @(negedge clk); chk("R9 stopped", 2'b00);
    zeros(RL);           chk("R9 stopped strobes", 2'b00);
    stop = 0; zeros(RL - 1); chk("R9 restart short", 2'b00);
    zeros(1);            chk("R9 restart full", 2'b11);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule